// File: doc/BRIEF.md
# DDR3 Command Scheduler with Per-Bank Row Tracking

This block sits between a queue of decoded memory accesses and the command pins of a DDR3 device. It takes the access at the head of the queue (read or write, bank, row, column) and turns it into the DDR3 command sequence needed to serve it. For each bank it remembers which row is open. A precharge goes out only when the requested row differs from the open one. An activate goes out only when the bank is closed. The read or write follows once the row-to-column delay has passed.

After reset the block first programs the mode register with a burst length of 4 or 8, chosen by a configuration input. Only then does it serve accesses. An internal interval timer requests auto-refresh. Refresh closes all banks with a precharge-all, waits out the precharge time, issues the refresh and then holds off for the refresh recovery time. The delays come in as cycle counts on configuration inputs and may be changed while no access is pending.

The block also controls its neighbouring data queues. A write issues only when the write-data queue holds a whole burst, and a read only when the read-data queue has room for one. Each issued read or write pulses a strobe and advances a burst-granular pointer into the matching data queue.

Top module: `ddr_cmd_sched`

## Requirements
- R1: While rst_n is low, ddr_cs_n, ddr_ras_n, ddr_cas_n and ddr_we_n are 1, ddr_ba and ddr_addr are 0, wdq_rd_ptr and rdq_wr_ptr are 0, and cq_pop, wdq_pop and rdq_push are 0.
- R2: Commands are encoded as {ddr_ras_n, ddr_cas_n, ddr_we_n} with ddr_cs_n low: mode load 000, refresh 001, precharge 010, activate 011, write 100, read 101. The first command after reset is a single mode load with ddr_ba = 0 and ddr_addr[1:0] = 00 when cfg_burst8 is 1 (burst of 8) or 10 when it is 0 (burst of 4). No other command precedes it.
- R3: An access to a closed bank issues an activate with ddr_ba = bank and ddr_addr = row. The read or write follows at least cfg_trcd cycles later, with ddr_addr[9:0] = column and ddr_addr[10] = 0.
- R4: An access whose row is already open in its bank issues the read or write with no precharge and no activate before it.
- R5: An access to a bank holding a different row issues a precharge to that bank with ddr_addr[10] = 0. An activate of the new row follows no sooner than cfg_trp cycles later, and then the access.
- R6: Open rows are tracked per bank: opening a row in one bank leaves the open row of every other bank intact.
- R7: A write issues only when wdq_count is at least the burst length. A read issues only when rdq_free is at least the burst length. Otherwise the access waits with the row open.
- R8: A refresh becomes due every cfg_trefi cycles. If any bank is open, the block first issues a precharge with ddr_addr[10] = 1, waits at least cfg_trp cycles, then issues refresh. No command follows a refresh for cfg_trfc cycles, and every bank counts as closed afterwards.
- R9: Each issued read or write pulses cq_pop for one cycle together with wdq_pop (write) or rdq_push (read). It advances wdq_rd_ptr or rdq_wr_ptr by the burst length, modulo 2^PTR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst8 | input | 1 | Burst length for the mode load: 1 = 8, 0 = 4 |
| cfg_trcd | input | TW | Activate-to-read/write delay in cycles (at least 2) |
| cfg_trp | input | TW | Precharge-to-activate delay in cycles (at least 2) |
| cfg_trfc | input | TW | Refresh recovery time in cycles (at least 2) |
| cfg_trefi | input | REFI_W | Refresh interval in cycles (at least 2) |
| cq_empty | input | 1 | Command queue has no entry |
| cq_write | input | 1 | Head entry is a write (1) or a read (0) |
| cq_bank | input | BA_W | Head entry bank |
| cq_row | input | ROW_W | Head entry row |
| cq_col | input | COL_W | Head entry column |
| cq_pop | output | 1 | Head entry consumed |
| wdq_count | input | CNT_W | Beats held in the write-data queue |
| rdq_free | input | CNT_W | Free beat slots in the read-data queue |
| wdq_pop | output | 1 | A write burst leaves the write-data queue |
| rdq_push | output | 1 | A read burst is booked into the read-data queue |
| wdq_rd_ptr | output | PTR_W | Write-data queue read pointer |
| rdq_wr_ptr | output | PTR_W | Read-data queue write pointer |
| ddr_cs_n | output | 1 | Chip select, low on a command |
| ddr_ras_n | output | 1 | Row strobe |
| ddr_cas_n | output | 1 | Column strobe |
| ddr_we_n | output | 1 | Write enable |
| ddr_ba | output | BA_W | Bank address |
| ddr_addr | output | ADDR_W | Row, column or mode address |

## Verification
The hardest situation to reach from the ports is a refresh that falls due while rows are still open. This is the only case that produces a precharge-all and forces rows to be reopened afterwards. The bench reaches it by resetting with a short refresh interval, opening a bank with a read, and waiting for the timer. It then requests the same row again and expects a fresh activate no sooner than the recovery time. A second hard case is an access stalled on data: the bench holds the data-queue levels one beat short of a burst and shows that nothing issues until the level reaches the burst length.

// File: rtl/ddr_sched_pkg.sv
// Shared types for the DDR3 command scheduler.
// Assumes commands are encoded on {ras_n, cas_n, we_n} with cs_n low.
package ddr_sched_pkg;

    typedef enum logic [2:0] {
        CMD_LMR = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_NOP = 3'b111
    } ddr_cmd_e;

    typedef enum logic [2:0] {
        ST_LMR,
        ST_IDLE,
        ST_WAIT,
        ST_ACT,
        ST_RW,
        ST_REF
    } sched_st_e;

    // Address bit that selects all banks on a precharge.
    localparam int AP_BIT = 10;

endpackage

// File: rtl/ddr_bank_table.sv
// Open-row table: one valid flag and one row register per bank.
// Lookup is combinational on the requested bank. Updates take effect at the
// next clock edge. A close of all banks wins over any single update.
module ddr_bank_table #(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BA_W-1:0]  look_bank,
    input  logic [ROW_W-1:0] look_row,
    output logic             look_open,
    output logic             look_hit,
    output logic             any_open,
    input  logic             open_en,
    input  logic             close_en,
    input  logic             close_all,
    input  logic [BA_W-1:0]  upd_bank,
    input  logic [ROW_W-1:0] upd_row
);

    logic [NUM_BANKS-1:0] open_q;
    logic [ROW_W-1:0]     row_q [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Track the open state and open row of bank b.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
                row_q[b]  <= '0;
            end else if (close_all || (close_en && upd_bank == BA_W'(b))) begin
                open_q[b] <= 1'b0;
            end else if (open_en && upd_bank == BA_W'(b)) begin
                open_q[b] <= 1'b1;
                row_q[b]  <= upd_row;
            end
        end
    end

    // Compare the requested row against the open row of its bank.
    always_comb begin
        look_open = open_q[look_bank];
        look_hit  = look_open && (row_q[look_bank] == look_row);
        any_open  = |open_q;
    end

endmodule

// File: rtl/ddr_refresh_timer.sv
// Refresh interval timer. Raises due once per interval and keeps it raised
// until acknowledged. At most one refresh is held pending.
// Assumes interval >= 2 cycles.
module ddr_refresh_timer #(
    parameter int REFI_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REFI_W-1:0] interval,
    input  logic              ack,
    output logic              due
);

    logic [REFI_W-1:0] cnt_q;
    logic              wrap;

    assign wrap = (cnt_q >= interval - REFI_W'(1));

    // Count cycles and latch a pending refresh at each interval end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            due   <= 1'b0;
        end else begin
            cnt_q <= wrap ? '0 : cnt_q + REFI_W'(1);
            if (wrap)
                due <= 1'b1;
            else if (ack)
                due <= 1'b0;
        end
    end

endmodule

// File: rtl/ddr_cmd_sched.sv
// DDR3 command scheduler. Serves the head of a decoded access queue with
// precharge/activate/read/write commands, tracks open rows per bank, loads
// the mode register once after reset and inserts periodic refresh.
// Assumes: the queue head is stable until cq_pop; all timing inputs >= 2
// and stable while an access is in flight; ADDR_W > 10 and COL_W <= 10.
// All command outputs are registered.
module ddr_cmd_sched
    import ddr_sched_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 10,
    parameter int ADDR_W    = 14,
    parameter int TW        = 8,
    parameter int REFI_W    = 16,
    parameter int PTR_W     = 5,
    parameter int CNT_W     = 6,
    parameter int MRD_CYC   = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_burst8,
    input  logic [TW-1:0]     cfg_trcd,
    input  logic [TW-1:0]     cfg_trp,
    input  logic [TW-1:0]     cfg_trfc,
    input  logic [REFI_W-1:0] cfg_trefi,
    input  logic              cq_empty,
    input  logic              cq_write,
    input  logic [BA_W-1:0]   cq_bank,
    input  logic [ROW_W-1:0]  cq_row,
    input  logic [COL_W-1:0]  cq_col,
    output logic              cq_pop,
    input  logic [CNT_W-1:0]  wdq_count,
    input  logic [CNT_W-1:0]  rdq_free,
    output logic              wdq_pop,
    output logic              rdq_push,
    output logic [PTR_W-1:0]  wdq_rd_ptr,
    output logic [PTR_W-1:0]  rdq_wr_ptr,
    output logic              ddr_cs_n,
    output logic              ddr_ras_n,
    output logic              ddr_cas_n,
    output logic              ddr_we_n,
    output logic [BA_W-1:0]   ddr_ba,
    output logic [ADDR_W-1:0] ddr_addr
);

    localparam logic [TW-1:0] MRD_WAIT = TW'(MRD_CYC - 1);

    sched_st_e         state_q, nxt_state, ret_q, nxt_ret;
    logic [TW-1:0]     wait_q, nxt_wait;
    ddr_cmd_e          cmd_q, nxt_cmd;
    logic [BA_W-1:0]   ba_q, nxt_ba;
    logic [ADDR_W-1:0] addr_q, nxt_addr;
    logic              bl8_q, nxt_bl8;
    logic              pop_q, wpop_q, rpush_q;
    logic              nxt_pop, nxt_wpop, nxt_rpush;
    logic [PTR_W-1:0]  wptr_q, rptr_q;

    logic look_open, look_hit, any_open;
    logic tbl_open, tbl_close, tbl_close_all;
    logic ref_due, ref_ack;

    logic [CNT_W-1:0] beats;
    logic [PTR_W-1:0] ptr_step;
    logic [TW-1:0]    rw_gap;
    logic             data_ready;

    ddr_bank_table #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W)
    ) i_bank_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_bank (cq_bank),
        .look_row  (cq_row),
        .look_open (look_open),
        .look_hit  (look_hit),
        .any_open  (any_open),
        .open_en   (tbl_open),
        .close_en  (tbl_close),
        .close_all (tbl_close_all),
        .upd_bank  (cq_bank),
        .upd_row   (cq_row)
    );

    ddr_refresh_timer #(
        .REFI_W (REFI_W)
    ) i_refresh_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (cfg_trefi),
        .ack      (ref_ack),
        .due      (ref_due)
    );

    // Burst-dependent quantities and data-queue readiness for the head access.
    always_comb begin
        beats      = bl8_q ? CNT_W'(8) : CNT_W'(4);
        ptr_step   = bl8_q ? PTR_W'(8) : PTR_W'(4);
        rw_gap     = bl8_q ? TW'(3) : TW'(1);
        data_ready = cq_write ? (wdq_count >= beats) : (rdq_free >= beats);
    end

    // Sequencing decisions: choose the next command, state and table updates.
    always_comb begin
        nxt_state     = state_q;
        nxt_ret       = ret_q;
        nxt_wait      = wait_q;
        nxt_cmd       = CMD_NOP;
        nxt_ba        = '0;
        nxt_addr      = '0;
        nxt_bl8       = bl8_q;
        nxt_pop       = 1'b0;
        nxt_wpop      = 1'b0;
        nxt_rpush     = 1'b0;
        tbl_open      = 1'b0;
        tbl_close     = 1'b0;
        tbl_close_all = 1'b0;
        ref_ack       = 1'b0;
        unique case (state_q)
            ST_LMR: begin
                nxt_cmd       = CMD_LMR;
                nxt_addr[1:0] = cfg_burst8 ? 2'b00 : 2'b10;
                nxt_bl8       = cfg_burst8;
                nxt_wait      = MRD_WAIT;
                nxt_ret       = ST_IDLE;
                nxt_state     = ST_WAIT;
            end
            ST_IDLE: begin
                if (ref_due) begin
                    if (any_open) begin
                        nxt_cmd          = CMD_PRE;
                        nxt_addr[AP_BIT] = 1'b1;
                        tbl_close_all    = 1'b1;
                        nxt_wait         = cfg_trp - TW'(1);
                        nxt_ret          = ST_REF;
                        nxt_state        = ST_WAIT;
                    end else begin
                        nxt_cmd   = CMD_REF;
                        ref_ack   = 1'b1;
                        nxt_wait  = cfg_trfc - TW'(1);
                        nxt_ret   = ST_IDLE;
                        nxt_state = ST_WAIT;
                    end
                end else if (!cq_empty) begin
                    if (look_hit) begin
                        nxt_state = ST_RW;
                    end else if (look_open) begin
                        nxt_cmd   = CMD_PRE;
                        nxt_ba    = cq_bank;
                        tbl_close = 1'b1;
                        nxt_wait  = cfg_trp - TW'(1);
                        nxt_ret   = ST_ACT;
                        nxt_state = ST_WAIT;
                    end else begin
                        nxt_cmd   = CMD_ACT;
                        nxt_ba    = cq_bank;
                        nxt_addr  = ADDR_W'(cq_row);
                        tbl_open  = 1'b1;
                        nxt_wait  = cfg_trcd - TW'(1);
                        nxt_ret   = ST_RW;
                        nxt_state = ST_WAIT;
                    end
                end
            end
            ST_ACT: begin
                nxt_cmd   = CMD_ACT;
                nxt_ba    = cq_bank;
                nxt_addr  = ADDR_W'(cq_row);
                tbl_open  = 1'b1;
                nxt_wait  = cfg_trcd - TW'(1);
                nxt_ret   = ST_RW;
                nxt_state = ST_WAIT;
            end
            ST_RW: begin
                if (data_ready) begin
                    nxt_cmd                = cq_write ? CMD_WR : CMD_RD;
                    nxt_ba                 = cq_bank;
                    nxt_addr[COL_W-1:0]    = cq_col;
                    nxt_pop                = 1'b1;
                    nxt_wpop               = cq_write;
                    nxt_rpush              = !cq_write;
                    nxt_wait               = rw_gap;
                    nxt_ret                = ST_IDLE;
                    nxt_state              = ST_WAIT;
                end
            end
            ST_REF: begin
                nxt_cmd   = CMD_REF;
                ref_ack   = 1'b1;
                nxt_wait  = cfg_trfc - TW'(1);
                nxt_ret   = ST_IDLE;
                nxt_state = ST_WAIT;
            end
            ST_WAIT: begin
                if (wait_q > TW'(1))
                    nxt_wait = wait_q - TW'(1);
                else
                    nxt_state = ret_q;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // Register state, command outputs, strobes and data-queue pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LMR;
            ret_q   <= ST_IDLE;
            wait_q  <= '0;
            cmd_q   <= CMD_NOP;
            ba_q    <= '0;
            addr_q  <= '0;
            bl8_q   <= 1'b1;
            pop_q   <= 1'b0;
            wpop_q  <= 1'b0;
            rpush_q <= 1'b0;
            wptr_q  <= '0;
            rptr_q  <= '0;
        end else begin
            state_q <= nxt_state;
            ret_q   <= nxt_ret;
            wait_q  <= nxt_wait;
            cmd_q   <= nxt_cmd;
            ba_q    <= nxt_ba;
            addr_q  <= nxt_addr;
            bl8_q   <= nxt_bl8;
            pop_q   <= nxt_pop;
            wpop_q  <= nxt_wpop;
            rpush_q <= nxt_rpush;
            if (nxt_wpop)
                wptr_q <= wptr_q + ptr_step;
            if (nxt_rpush)
                rptr_q <= rptr_q + ptr_step;
        end
    end

    // Drive the ports from the registered command.
    always_comb begin
        ddr_cs_n                          = (cmd_q == CMD_NOP);
        {ddr_ras_n, ddr_cas_n, ddr_we_n}  = cmd_q;
        ddr_ba                            = ba_q;
        ddr_addr                          = addr_q;
        cq_pop                            = pop_q;
        wdq_pop                           = wpop_q;
        rdq_push                          = rpush_q;
        wdq_rd_ptr                        = wptr_q;
        rdq_wr_ptr                        = rptr_q;
    end

endmodule

// File: rtl/ddr_cmd_sched_chk.sv
// Protocol checker for the DDR3 command scheduler, watching ports only.
// Keeps its own model of open banks and of cycles since each bank's last
// precharge and activate, and checks command ordering against them.
module ddr_cmd_sched_chk #(
    parameter int NUM_BANKS = 8,
    parameter int TW        = 8,
    parameter int CNT_W     = 6,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TW-1:0]    cfg_trcd,
    input logic [TW-1:0]    cfg_trp,
    input logic [CNT_W-1:0] wdq_count,
    input logic [CNT_W-1:0] rdq_free,
    input logic             cq_pop,
    input logic             wdq_pop,
    input logic             rdq_push,
    input logic             ddr_cs_n,
    input logic             ddr_ras_n,
    input logic             ddr_cas_n,
    input logic             ddr_we_n,
    input logic [BA_W-1:0]  ddr_ba,
    input logic             all_bit,
    input logic [1:0]       mode_bits
);

    logic [2:0]           cmd;
    logic                 iss, is_lmr, is_ref, is_pre, is_act, is_wr, is_rd, is_rw;
    logic                 lmr_seen;
    logic [CNT_W-1:0]     beats_q;
    logic [NUM_BANKS-1:0] open_m;
    logic [15:0]          since_pre [NUM_BANKS];
    logic [15:0]          since_act [NUM_BANKS];

    // Decode the command on the pins.
    always_comb begin
        cmd    = {ddr_ras_n, ddr_cas_n, ddr_we_n};
        iss    = !ddr_cs_n;
        is_lmr = iss && cmd == 3'b000;
        is_ref = iss && cmd == 3'b001;
        is_pre = iss && cmd == 3'b010;
        is_act = iss && cmd == 3'b011;
        is_wr  = iss && cmd == 3'b100;
        is_rd  = iss && cmd == 3'b101;
        is_rw  = is_wr || is_rd;
    end

    // Model mode-load history, burst length and open banks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lmr_seen <= 1'b0;
            beats_q  <= CNT_W'(8);
            open_m   <= '0;
        end else begin
            if (is_lmr) begin
                lmr_seen <= 1'b1;
                beats_q  <= (mode_bits == 2'b00) ? CNT_W'(8) : CNT_W'(4);
            end
            if (is_act)
                open_m[ddr_ba] <= 1'b1;
            else if (is_pre && all_bit)
                open_m <= '0;
            else if (is_pre)
                open_m[ddr_ba] <= 1'b0;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_age
        // Count cycles since the last precharge and activate of bank b.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                since_pre[b] <= '1;
                since_act[b] <= '0;
            end else begin
                if (is_pre && (all_bit || ddr_ba == BA_W'(b)))
                    since_pre[b] <= 16'd1;
                else if (since_pre[b] != '1)
                    since_pre[b] <= since_pre[b] + 16'd1;
                if (is_act && ddr_ba == BA_W'(b))
                    since_act[b] <= 16'd1;
                else if (since_act[b] != '1)
                    since_act[b] <= since_act[b] + 16'd1;
            end
        end
    end

    assert_lmr_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss && !is_lmr) |-> lmr_seen);
    assert_lmr_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_lmr |-> !lmr_seen);
    assert_act_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> !open_m[ddr_ba]);
    assert_rw_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_rw |-> open_m[ddr_ba]);
    assert_trcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_rw |-> since_act[ddr_ba] >= 16'(cfg_trcd));
    assert_trp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> since_pre[ddr_ba] >= 16'(cfg_trp));
    assert_wr_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |-> $past(wdq_count) >= beats_q);
    assert_rd_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> $past(rdq_free) >= beats_q);
    assert_ref_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> open_m == '0);
    assert_pop_with_rw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        is_rw |-> cq_pop);
    assert_rw_with_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cq_pop |-> is_rw);
    assert_wdq_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wdq_pop |-> is_wr);
    assert_rdq_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rdq_push |-> is_rd);

endmodule

bind ddr_cmd_sched ddr_cmd_sched_chk #(
    .NUM_BANKS (NUM_BANKS),
    .TW        (TW),
    .CNT_W     (CNT_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_trcd  (cfg_trcd),
    .cfg_trp   (cfg_trp),
    .wdq_count (wdq_count),
    .rdq_free  (rdq_free),
    .cq_pop    (cq_pop),
    .wdq_pop   (wdq_pop),
    .rdq_push  (rdq_push),
    .ddr_cs_n  (ddr_cs_n),
    .ddr_ras_n (ddr_ras_n),
    .ddr_cas_n (ddr_cas_n),
    .ddr_we_n  (ddr_we_n),
    .ddr_ba    (ddr_ba),
    .all_bit   (ddr_addr[10]),
    .mode_bits (ddr_addr[1:0])
);

// File: tb/test_ddr_cmd_sched.sv
`timescale 1ns/1ps
// Directed bench for the DDR3 command scheduler. A queue model feeds the
// head entry, a monitor logs every command at the falling edge, and each
// scenario task checks the log and the data-queue ports.
module test_ddr_cmd_sched;

    localparam int TRCD = 6;
    localparam int TRP  = 6;
    localparam int TRFC = 44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_burst8 = 1'b1;
    logic [7:0]  cfg_trcd = 8'(TRCD);
    logic [7:0]  cfg_trp  = 8'(TRP);
    logic [7:0]  cfg_trfc = 8'(TRFC);
    logic [15:0] cfg_trefi = 16'd60000;
    logic        cq_empty, cq_write, cq_pop;
    logic [2:0]  cq_bank;
    logic [13:0] cq_row;
    logic [9:0]  cq_col;
    logic [5:0]  wdq_count = '0;
    logic [5:0]  rdq_free = '0;
    logic        wdq_pop, rdq_push;
    logic [4:0]  wdq_rd_ptr, rdq_wr_ptr;
    logic        ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
    logic [2:0]  ddr_ba;
    logic [13:0] ddr_addr;

    int checks = 0;
    int errors = 0;

    // Queue model
    logic        q_wr  [64];
    logic [2:0]  q_ba  [64];
    logic [13:0] q_row [64];
    logic [9:0]  q_col [64];
    int q_n = 0;
    int q_idx = 0;

    assign cq_empty = (q_idx >= q_n);
    assign cq_write = q_wr[q_idx[5:0]];
    assign cq_bank  = q_ba[q_idx[5:0]];
    assign cq_row   = q_row[q_idx[5:0]];
    assign cq_col   = q_col[q_idx[5:0]];

    // Command log
    logic [2:0]  l_cmd  [512];
    logic [2:0]  l_ba   [512];
    logic [13:0] l_addr [512];
    int          l_cyc  [512];
    int log_n = 0;
    int cyc = 0;
    int n_pop = 0;
    int n_wpop = 0;
    int n_rpush = 0;

    always #2.5 clk = ~clk;

    ddr_cmd_sched i_ddr_cmd_sched (
        .clk (clk), .rst_n (rst_n), .cfg_burst8 (cfg_burst8),
        .cfg_trcd (cfg_trcd), .cfg_trp (cfg_trp), .cfg_trfc (cfg_trfc),
        .cfg_trefi (cfg_trefi), .cq_empty (cq_empty), .cq_write (cq_write),
        .cq_bank (cq_bank), .cq_row (cq_row), .cq_col (cq_col),
        .cq_pop (cq_pop), .wdq_count (wdq_count), .rdq_free (rdq_free),
        .wdq_pop (wdq_pop), .rdq_push (rdq_push), .wdq_rd_ptr (wdq_rd_ptr),
        .rdq_wr_ptr (rdq_wr_ptr), .ddr_cs_n (ddr_cs_n),
        .ddr_ras_n (ddr_ras_n), .ddr_cas_n (ddr_cas_n), .ddr_we_n (ddr_we_n),
        .ddr_ba (ddr_ba), .ddr_addr (ddr_addr)
    );

    // Monitor: log commands, advance the queue head, count strobes.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!ddr_cs_n && log_n < 512) begin
            l_cmd[log_n]  = {ddr_ras_n, ddr_cas_n, ddr_we_n};
            l_ba[log_n]   = ddr_ba;
            l_addr[log_n] = ddr_addr;
            l_cyc[log_n]  = cyc;
            log_n = log_n + 1;
        end
        if (cq_pop)   q_idx   = q_idx + 1;
        if (cq_pop)   n_pop   = n_pop + 1;
        if (wdq_pop)  n_wpop  = n_wpop + 1;
        if (rdq_push) n_rpush = n_rpush + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int find_cmd(input int from, input logic [2:0] c);
        for (int i = from; i < log_n; i++)
            if (l_cmd[i] == c) return i;
        return -1;
    endfunction

    task automatic push_cmd(input logic w, input logic [2:0] b,
                            input logic [13:0] r, input logic [9:0] c);
        q_wr[q_n] = w; q_ba[q_n] = b; q_row[q_n] = r; q_col[q_n] = c;
        q_n = q_n + 1;
    endtask

    task automatic do_reset(input logic b8, input logic [15:0] refi, output int mark);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_burst8 = b8;
        cfg_trefi = refi;
        wdq_count = '0;
        rdq_free = '0;
        repeat (3) @(negedge clk);
        mark = log_n;
        rst_n = 1'b1;
    endtask

    // R1 and R2: outputs during reset, then a single mode load with burst 8.
    task automatic t_reset(output int s);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_burst8 = 1'b1;
        repeat (2) @(negedge clk);
        chk(ddr_cs_n && ddr_ras_n && ddr_cas_n && ddr_we_n, "R1", "command pins idle",
            int'({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}), 15);
        chk(ddr_addr == 0 && ddr_ba == 0, "R1", "address and bank zero",
            int'(ddr_addr), 0);
        chk(wdq_rd_ptr == 0 && rdq_wr_ptr == 0, "R1", "pointers zero",
            int'({wdq_rd_ptr, rdq_wr_ptr}), 0);
        chk(!cq_pop && !wdq_pop && !rdq_push, "R1", "strobes low",
            int'({cq_pop, wdq_pop, rdq_push}), 0);
        s = log_n;
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        chk(log_n - s == 1, "R2", "command count after reset", log_n - s, 1);
        chk(l_cmd[s] == 3'b000, "R2", "first command is mode load", int'(l_cmd[s]), 0);
        chk(l_addr[s][1:0] == 2'b00 && l_ba[s] == 0, "R2", "burst 8 mode bits",
            int'(l_addr[s][1:0]), 0);
    endtask

    // R3 and R9: write to a closed bank.
    task automatic t_closed_write(input int s);
        int a;
        wdq_count = 6'd8;
        push_cmd(1'b1, 3'd0, 14'd5, 10'h12);
        repeat (40) @(negedge clk);
        a = s + 1;
        chk(l_cmd[a] == 3'b011 && l_ba[a] == 0 && l_addr[a] == 14'd5, "R3",
            "activate bank0 row5", int'(l_addr[a]), 5);
        chk(l_cmd[a+1] == 3'b100 && l_addr[a+1] == 14'h12, "R3",
            "write column 0x12 without autoprecharge", int'(l_addr[a+1]), 'h12);
        chk(l_cyc[a+1] - l_cyc[a] >= TRCD, "R3", "activate to write gap",
            l_cyc[a+1] - l_cyc[a], TRCD);
        chk(wdq_rd_ptr == 5'd8, "R9", "write pointer after one burst", int'(wdq_rd_ptr), 8);
        chk(n_pop == 1 && n_wpop == 1 && n_rpush == 0, "R9", "pop and write strobe counts",
            n_pop * 100 + n_wpop * 10 + n_rpush, 110);
    endtask

    // R4 then R5: row hit and row miss on bank 0.
    task automatic t_hit_miss();
        int s;
        rdq_free = 6'd8;
        s = log_n;
        push_cmd(1'b0, 3'd0, 14'd5, 10'h20);
        repeat (40) @(negedge clk);
        chk(log_n - s == 1 && l_cmd[s] == 3'b101 && l_addr[s] == 14'h20, "R4",
            "hit issues read only", log_n - s, 1);
        chk(rdq_wr_ptr == 5'd8, "R9", "read pointer after one burst", int'(rdq_wr_ptr), 8);
        s = log_n;
        push_cmd(1'b0, 3'd0, 14'd9, 10'd3);
        repeat (60) @(negedge clk);
        chk(l_cmd[s] == 3'b010 && l_ba[s] == 0 && !l_addr[s][10], "R5",
            "single-bank precharge", int'(l_cmd[s]), 2);
        chk(l_cmd[s+1] == 3'b011 && l_addr[s+1] == 14'd9, "R5", "activate new row",
            int'(l_addr[s+1]), 9);
        chk(l_cyc[s+1] - l_cyc[s] >= TRP, "R5", "precharge to activate gap",
            l_cyc[s+1] - l_cyc[s], TRP);
        chk(l_cmd[s+2] == 3'b101 && log_n - s == 3, "R5", "read after miss",
            int'(l_cmd[s+2]), 5);
        chk(rdq_wr_ptr == 5'd16, "R9", "read pointer after two bursts", int'(rdq_wr_ptr), 16);
    endtask

    // R6: interleaving two banks keeps both rows open.
    task automatic t_banks();
        int s;
        s = log_n;
        push_cmd(1'b0, 3'd1, 14'd3, 10'd1);
        push_cmd(1'b0, 3'd2, 14'd4, 10'd2);
        push_cmd(1'b0, 3'd1, 14'd3, 10'd7);
        repeat (100) @(negedge clk);
        chk(log_n - s == 5, "R6", "commands for three accesses", log_n - s, 5);
        chk(find_cmd(s, 3'b010) < 0, "R6", "no precharge", find_cmd(s, 3'b010), -1);
        chk(l_cmd[s+4] == 3'b101 && l_ba[s+4] == 1 && l_addr[s+4] == 14'd7, "R6",
            "bank1 reread is a hit", int'(l_cmd[s+4]), 5);
    endtask

    // R2, R7, R9 with burst 4: exactly four beats suffice.
    task automatic t_burst4();
        int s;
        do_reset(1'b0, 16'd60000, s);
        wdq_count = 6'd4;
        push_cmd(1'b1, 3'd4, 14'd1, 10'd0);
        repeat (40) @(negedge clk);
        chk(l_cmd[s] == 3'b000 && l_addr[s][1:0] == 2'b10, "R2", "burst 4 mode bits",
            int'(l_addr[s][1:0]), 2);
        chk(l_cmd[s+2] == 3'b100, "R7", "write with four beats at burst 4",
            int'(l_cmd[s+2]), 4);
        chk(wdq_rd_ptr == 5'd4, "R9", "pointer step at burst 4", int'(wdq_rd_ptr), 4);
    endtask

    // R7: accesses stall one beat short of a burst.
    task automatic t_starve();
        int s, p;
        do_reset(1'b1, 16'd60000, s);
        wdq_count = 6'd7;
        p = n_pop;
        push_cmd(1'b1, 3'd5, 14'd2, 10'd1);
        repeat (60) @(negedge clk);
        chk(find_cmd(s, 3'b100) < 0 && n_pop == p, "R7", "write held with 7 beats",
            n_pop - p, 0);
        wdq_count = 6'd8;
        repeat (20) @(negedge clk);
        chk(find_cmd(s, 3'b100) > 0, "R7", "write issues with 8 beats",
            find_cmd(s, 3'b100) > 0 ? 1 : 0, 1);
        rdq_free = 6'd7;
        p = n_pop;
        push_cmd(1'b0, 3'd5, 14'd2, 10'd2);
        repeat (40) @(negedge clk);
        chk(find_cmd(s, 3'b101) < 0 && n_pop == p, "R7", "read held with 7 free",
            n_pop - p, 0);
        rdq_free = 6'd8;
        repeat (20) @(negedge clk);
        chk(find_cmd(s, 3'b101) > 0, "R7", "read issues with 8 free",
            find_cmd(s, 3'b101) > 0 ? 1 : 0, 1);
    endtask

    // R8: refresh with an open bank, then the row must be reopened.
    task automatic t_refresh();
        int s, r;
        do_reset(1'b1, 16'd300, s);
        rdq_free = 6'd8;
        push_cmd(1'b0, 3'd3, 14'd7, 10'd0);
        r = -1;
        for (int i = 0; i < 800 && r < 0; i++) begin
            @(negedge clk);
            r = find_cmd(s, 3'b001);
        end
        chk(r > 0, "R8", "refresh seen", r, 1);
        if (r > 0) begin
            chk(l_cmd[r-1] == 3'b010 && l_addr[r-1][10], "R8", "precharge-all before refresh",
                int'(l_cmd[r-1]), 2);
            chk(l_cyc[r] - l_cyc[r-1] >= TRP, "R8", "precharge-all to refresh gap",
                l_cyc[r] - l_cyc[r-1], TRP);
            push_cmd(1'b0, 3'd3, 14'd7, 10'd1);
            repeat (120) @(negedge clk);
            chk(l_cmd[r+1] == 3'b011 && l_ba[r+1] == 3 && l_addr[r+1] == 14'd7, "R8",
                "row reopened after refresh", int'(l_cmd[r+1]), 3);
            chk(l_cyc[r+1] - l_cyc[r] >= TRFC, "R8", "refresh recovery gap",
                l_cyc[r+1] - l_cyc[r], TRFC);
            chk(l_cmd[r+2] == 3'b101, "R8", "read after reopen", int'(l_cmd[r+2]), 5);
        end
    endtask

    initial begin
        int s;
        t_reset(s);
        t_closed_write(s);
        t_hit_miss();
        t_banks();
        t_burst4();
        t_starve();
        t_refresh();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule